// File: doc/BRIEF.md
# Hold/Toggle Period Sequencer

This block cuts the shift phase of every test pattern into alternating windows. During a toggle window the pseudorandom generator's per-bit latches follow their normal per-pattern enables. During a hold window a single freeze line forces every one of those latches to keep its value. The lengths of the two windows come from two 4-bit programmable values, so software can set the duty cycle of generator activity inside a pattern.

A single state bit records the current window. It works like a T flip-flop: it inverts only when a one-cycle end-of-window strike reaches it. That strike comes from a down-counter. When a window closes, the counter is reloaded with the length of the window that follows. The block keeps working copies of the two lengths. It takes these copies only when a new pattern starts, so writes made during shift or capture cannot change the window lengths in the middle of a pattern. The counter and the state bit move only on shift cycles. They stand still during capture cycles.

Top module: `hold_toggle_seq`

## Requirements
- R1: After an asynchronous reset, `freeze` is 0 and both programmed lengths are 0.
- R2: On a `pat_start` cycle the block enters a toggle window (`freeze` is 0 after that edge) that lasts T+1 shift cycles, where T is the toggle length programmed at that moment.
- R3: A hold window lasts H+1 shift cycles with `freeze` at 1, where H is the working hold length. The block then returns to a toggle window of T+1 shift cycles, and the windows keep alternating.
- R4: A cycle with `shift_en` low leaves `freeze` and the remaining window length unchanged.
- R5: A cycle with `capture` high leaves `freeze` and the remaining window length unchanged, even when `shift_en` is high.
- R6: A write with `wr_en` high stores `wr_data` as the hold length when `wr_sel` is 0 and as the toggle length when `wr_sel` is 1. The write takes effect only at the next `pat_start`. Until then the current pattern keeps its working lengths.
- R7: `pat_start` takes priority over an advancing shift cycle. After that edge, `freeze` is 0 even if it was 1 before.
- R8: `freeze` is registered and changes on the clock edge of the last shift cycle of a window. Length 0 gives windows of one shift cycle, and length 15 gives windows of sixteen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Scan shift cycle |
| capture | input | 1 | Capture cycle; stalls the sequencer |
| pat_start | input | 1 | Start of a new pattern; takes working lengths, enters toggle window |
| wr_en | input | 1 | Write strobe for a programmed length |
| wr_sel | input | 1 | 0 selects hold length, 1 selects toggle length |
| wr_data | input | CNT_W | Length value to write |
| freeze | output | 1 | 1 during hold windows: all generator latches held |

## Verification
The assertions check on every cycle that the sequencer stalls when no shift cycle advances it, that a pattern start always leaves `freeze` low, that the working lengths change only at a pattern start, and that `freeze` inverts exactly when a window's count runs out. Only the bench scenarios can show the actual window lengths in shift cycles, including the extremes of one and sixteen cycles. The same holds for a write made during capture having no effect until the next pattern, and for reset clearing the programmed lengths, which the bench observes through the length of the first window after reset.

// File: rtl/hold_toggle_seq.sv
module hold_toggle_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             capture,
  input  logic             pat_start,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             freeze
);

  logic [CNT_W-1:0] prog_hold, prog_tog;
  logic [CNT_W-1:0] sh_hold, sh_tog;
  logic [CNT_W-1:0] cnt;
  logic             in_hold;

  wire advance = shift_en && !capture && !pat_start;
  wire t_in    = advance && (cnt == '0);
  wire [CNT_W-1:0] reload = in_hold ? sh_tog : sh_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_hold <= '0;
      prog_tog  <= '0;
    end else if (wr_en) begin
      if (wr_sel) prog_tog  <= wr_data;
      else        prog_hold <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_hold <= '0;
      sh_tog  <= '0;
    end else if (pat_start) begin
      sh_hold <= prog_hold;
      sh_tog  <= prog_tog;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hold <= 1'b0;
      cnt     <= '0;
    end else if (pat_start) begin
      in_hold <= 1'b0;
      cnt     <= prog_tog;
    end else if (advance) begin
      if (t_in) begin
        in_hold <= ~in_hold;
        cnt     <= reload;
      end else begin
        cnt     <= cnt - 1'b1;
      end
    end
  end

  assign freeze = in_hold;

  AST_START_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pat_start |=> !freeze); // R7

  AST_IDLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!pat_start && !shift_en) |=> ($stable(freeze) && $stable(cnt))); // R4

  AST_CAPTURE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!pat_start && capture) |=> ($stable(freeze) && $stable(cnt))); // R5

  AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_start |=> ($stable(sh_hold) && $stable(sh_tog))); // R6

  AST_NO_EARLY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && cnt != '0) |=> $stable(freeze)); // R3

  AST_FLIP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && cnt == '0) |=> (freeze != $past(freeze))); // R8

endmodule

// File: tb/hold_toggle_seq_bench.sv
module hold_toggle_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b0, capture = 1'b0, pat_start = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [3:0] wr_data = '0;
  logic freeze;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hold_toggle_seq u_hold_toggle_seq (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .capture(capture),
    .pat_start(pat_start), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .freeze(freeze)
  );

  // {shift_en, capture, pat_start, wr_en, wr_sel, wr_data[3:0], expected freeze}
  localparam logic [9:0] VEC [NV] = '{
    10'b0_0_0_1_0_0010_0, // hold=2
    10'b0_0_0_1_1_0001_0, // toggle=1
    10'b0_0_1_0_0_0000_0, // start
    10'b1_0_0_0_0_0000_0,
    10'b1_0_0_0_0_0000_1, // toggle window 2 cycles
    10'b1_0_0_0_0_0000_1,
    10'b1_1_0_0_0_0000_1, // capture stalls
    10'b0_1_0_1_0_0101_1, // write hold=5 during capture
    10'b1_0_0_0_0_0000_1,
    10'b1_0_0_0_0_0000_0, // hold window 3 cycles
    10'b1_0_0_0_0_0000_0,
    10'b1_0_0_0_0_0000_1,
    10'b1_0_0_0_0_0000_1,
    10'b1_0_0_0_0_0000_1,
    10'b1_0_0_0_0_0000_0, // still 3: working copy kept
    10'b0_0_0_0_0_0000_0,
    10'b0_0_1_0_0_0000_0, // start takes hold=5
    10'b1_0_0_0_0_0000_0,
    10'b1_0_0_0_0_0000_1,
    10'b1_0_0_0_0_0000_1,
    10'b1_0_0_0_0_0000_1,
    10'b0_0_0_0_0_0000_1, // idle stall
    10'b1_0_0_0_0_0000_1,
    10'b1_0_0_0_0_0000_1,
    10'b1_0_0_0_0_0000_1,
    10'b1_0_0_0_0_0000_0, // hold window 6 cycles
    10'b1_0_0_0_0_0000_0,
    10'b1_0_0_0_0_0000_1,
    10'b1_0_1_0_0_0000_0  // start beats shift
  };

  task automatic check(input logic exp, input string tag);
    checks++;
    if (freeze !== exp) begin
      errors++;
      $display("FAIL %s: freeze=%0b expected=%0b", tag, freeze, exp);
    end
  endtask

  task automatic drive(input logic se, input logic cap, input logic ps,
                       input logic we, input logic ws, input logic [3:0] d);
    shift_en = se; capture = cap; pat_start = ps;
    wr_en = we; wr_sel = ws; wr_data = d;
    @(posedge clk);
    #1;
    shift_en = 1'b0; capture = 1'b0; pat_start = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hi_cnt;
    #(CLK_PERIOD*2 + 1);
    check(1'b0, "R1 reset freeze");
    @(posedge clk); #1;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4:1]);
      check(VEC[i][0], $sformatf("R2 R3 R4 R5 R6 R7 vector %0d", i));
    end

    // R8: length 0 on both windows alternates every shift cycle
    drive(0, 0, 0, 1, 0, 4'd0);
    drive(0, 0, 0, 1, 1, 4'd0);
    drive(0, 0, 1, 0, 0, 4'd0);
    check(1'b0, "R8 len0 start");
    for (int k = 0; k < 4; k++) begin
      drive(1, 0, 0, 0, 0, 4'd0);
      check(k[0] ? 1'b0 : 1'b1, "R8 len0 alternate");
    end

    // R8: hold length 15 gives sixteen frozen shift cycles
    drive(0, 0, 0, 1, 0, 4'd15);
    drive(0, 0, 1, 0, 0, 4'd0);
    drive(1, 0, 0, 0, 0, 4'd0);
    check(1'b1, "R3 enter hold");
    hi_cnt = 1;
    for (int k = 0; k < 20 && freeze; k++) begin
      drive(1, 0, 0, 0, 0, 4'd0);
      if (freeze) hi_cnt++;
    end
    checks++;
    if (hi_cnt != 16) begin
      errors++;
      $display("FAIL R8 len15 hold cycles=%0d expected=16", hi_cnt);
    end

    // R1: reset mid-hold clears freeze and programmed lengths
    drive(0, 0, 0, 1, 1, 4'd3);
    drive(0, 0, 1, 0, 0, 4'd0);
    for (int k = 0; k < 4; k++) drive(1, 0, 0, 0, 0, 4'd0);
    check(1'b1, "R2 toggle=3 reached hold");
    rst_n = 1'b0;
    #1;
    check(1'b0, "R1 reset mid-hold");
    @(posedge clk); #1;
    rst_n = 1'b1;
    drive(0, 0, 1, 0, 0, 4'd0);
    drive(1, 0, 0, 0, 0, 4'd0);
    check(1'b1, "R1 toggle length cleared");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule